// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits in front of a page write controller. It watches every byte/word load (an address and data pair) and keeps a protected flag. While the flag is clear, ordinary loads pass straight through. While it is set, a load reaches the array only if a three-step unlock prefix came earlier in the same load window. A six-step sequence clears the flag. Every load that matches a sequence step is marked as a command, so it never overwrites the location it addresses.

The page write controller owns the load window timing. Command loads follow the same inter-load timing rules as data loads. The controller pulses `win_close` when the window ends and the internal programming period begins. Arming or disarming takes effect on that pulse, even if no data load followed the sequence. Each sequence step must carry its byte pattern in every byte lane: lane i occupies data bits [8i+7:8i]. `LANES` sets the configuration to 8, 16 or 32 bits.

Top module: `swp_seq`

## Requirements
- R1: After reset `prot_on` is 0 and the detector is idle. With no load presented, `ld_allow` and `ld_cmd` are 0.
- R2: While `prot_on` is 0, a load that matches no sequence step gives `ld_allow`=1 and `ld_cmd`=0 in the same cycle.
- R3: While `prot_on` is 1 and no prefix has completed in the current window, a non-command load gives `ld_allow`=0.
- R4: The unlock prefix is AA at address 5555h, then 55 at 2AAAh, then A0 at 5555h. Each of these loads, in order, gives `ld_cmd`=1 and `ld_allow`=0.
- R5: After a completed prefix, up to `PAGE_WORDS` (default 64) further loads in the same window give `ld_allow`=1, even while protected. Any load after that in the window gives `ld_allow`=0.
- R6: A completed prefix sets `prot_on` to 1 in the cycle after the `win_close` pulse, even if no data load followed. `prot_on` does not change before that pulse.
- R7: The clear sequence is AA@5555h, 55@2AAAh, 80@5555h, AA@5555h, 55@2AAAh, 20@5555h. All six loads are commands. Loads after it in the window are allowed, and `prot_on` goes to 0 in the cycle after `win_close`.
- R8: A load that does not match the expected next step returns the detector to idle. That load is then judged as a first step: AA@5555h starts a new sequence; anything else is a plain load.
- R9: A step matches only if every one of the `LANES` byte lanes holds the pattern byte. A load with a single differing lane is a plain load.
- R10: `prot_on` changes only in the cycle after a `win_close` pulse.
- R11: A new window starts idle. Prefix progress and unlock from an earlier window do not carry over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | One-cycle strobe: a byte/word load is presented |
| ld_addr | input | ADDR_W | Load address |
| ld_data | input | 8*LANES | Load data, lane i in bits [8i+7:8i] |
| win_close | input | 1 | Load window ended; pending arm/disarm takes effect |
| ld_allow | output | 1 | Current load may be written into the page buffer |
| ld_cmd | output | 1 | Current load is a command step and must not be stored |
| prot_on | output | 1 | Protected state |

## Verification
On every cycle, the assertions check the following:
- a command load is never allowed;
- nothing is flagged without a load;
- a protected, unqualified load is blocked;
- the post-prefix load count stays within the page;
- the detector is idle after a window closes;
- the protected flag moves only after a window close.

Only the bench scenarios can show the sequence contents themselves. These are the exact prefix and clear orders, the restart of a broken sequence on its offending load, the all-lanes rule, the page-size limit at its 64/65 boundary, and arm/disarm taking effect with no data following.

// File: rtl/swp_pkg.sv
// Shared types and command-step constants for the write protection sequencer.
// Assumes byte patterns are replicated across all byte lanes of a load.
package swp_pkg;

    // Detector progress through the command sequences.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,  // expecting first step
        ST_K1    = 3'd1,  // AA@5555 seen
        ST_K2    = 3'd2,  // 55@2AAA seen
        ST_D3    = 3'd3,  // 80@5555 seen (clear path)
        ST_D4    = 3'd4,  // AA@5555 seen on clear path
        ST_D5    = 3'd5,  // 55@2AAA seen on clear path
        ST_OPEN  = 3'd6   // prefix or clear complete: data loads qualified
    } swp_state_e;

    localparam int NUM_TOK = 5;

    // Token indices: which address/pattern pair each matcher detects.
    localparam int TOK_AA_LO = 0;  // AA at 5555h
    localparam int TOK_55_HI = 1;  // 55 at 2AAAh
    localparam int TOK_A0_LO = 2;  // A0 at 5555h
    localparam int TOK_80_LO = 3;  // 80 at 5555h
    localparam int TOK_20_LO = 4;  // 20 at 5555h

    localparam logic [NUM_TOK-1:0][7:0]  TOK_BYTE = {8'h20, 8'h80, 8'hA0, 8'h55, 8'hAA};
    localparam logic [NUM_TOK-1:0][15:0] TOK_ADDR = {16'h5555, 16'h5555, 16'h5555, 16'h2AAA, 16'h5555};

endpackage

// File: rtl/swp_lane_match.sv
// Detects one command step: address equals KEY_ADDR and every byte lane of
// the data equals KEY_BYTE. Purely combinational.
// Assumes ADDR_W >= 15 so the key addresses fit.
module swp_lane_match #(
    parameter int          LANES    = 4,
    parameter int          ADDR_W   = 15,
    parameter logic [15:0] KEY_ADDR = 16'h5555,
    parameter logic [7:0]  KEY_BYTE = 8'hAA
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [8*LANES-1:0] data,
    output logic               hit
);
    localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(KEY_ADDR);

    logic [LANES-1:0] lane_eq;

    // One comparator per byte lane.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_eq[i] = (data[8*i +: 8] == KEY_BYTE);
    end

    // A step matches only with all lanes and the address equal.
    assign hit = (&lane_eq) && (addr == KEY_A);

endmodule

// File: rtl/swp_step_fsm.sv
// Sequence detector. It steps through the unlock prefix and the clear sequence on each
// load, flags command loads, qualifies data loads after a completed sequence
// (limited to PAGE_WORDS per window) and raises arm/disarm requests.
// Assumes win_close and ld_valid are never high in the same cycle; if they
// are, the window close wins and the load does not advance the detector.
module swp_step_fsm
    import swp_pkg::*;
#(
    parameter int PAGE_WORDS = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_valid,
    input  logic               win_close,
    input  logic [NUM_TOK-1:0] tok,
    input  logic               prot,
    output logic               is_cmd,
    output logic               allow,
    output logic               open_o,
    output logic               arm_req,
    output logic               disarm_req
);
    localparam int              CNT_W   = $clog2(PAGE_WORDS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PAGE_WORDS);

    swp_state_e       st_q, st_nxt, restart_st;
    logic [CNT_W-1:0] cnt_q;
    logic             cmd_c, qual_c, arm_c, disarm_c, restart_cmd, room;

    // Where a broken sequence lands: the offending load is judged as a first step.
    always_comb begin
        restart_st  = tok[TOK_AA_LO] ? ST_K1 : ST_IDLE;
        restart_cmd = tok[TOK_AA_LO];
    end

    // Next-state and command classification for the presented load.
    always_comb begin
        st_nxt   = st_q;
        cmd_c    = 1'b0;
        qual_c   = 1'b0;
        arm_c    = 1'b0;
        disarm_c = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                st_nxt = restart_st;
                cmd_c  = restart_cmd;
            end
            ST_K1: begin
                if (tok[TOK_55_HI]) begin
                    st_nxt = ST_K2;
                    cmd_c  = 1'b1;
                end else begin
                    st_nxt = restart_st;
                    cmd_c  = restart_cmd;
                end
            end
            ST_K2: begin
                if (tok[TOK_A0_LO]) begin
                    st_nxt = ST_OPEN;
                    cmd_c  = 1'b1;
                    arm_c  = 1'b1;
                end else if (tok[TOK_80_LO]) begin
                    st_nxt = ST_D3;
                    cmd_c  = 1'b1;
                end else begin
                    st_nxt = restart_st;
                    cmd_c  = restart_cmd;
                end
            end
            ST_D3: begin
                if (tok[TOK_AA_LO]) begin
                    st_nxt = ST_D4;
                    cmd_c  = 1'b1;
                end else begin
                    st_nxt = restart_st;
                    cmd_c  = restart_cmd;
                end
            end
            ST_D4: begin
                if (tok[TOK_55_HI]) begin
                    st_nxt = ST_D5;
                    cmd_c  = 1'b1;
                end else begin
                    st_nxt = restart_st;
                    cmd_c  = restart_cmd;
                end
            end
            ST_D5: begin
                if (tok[TOK_20_LO]) begin
                    st_nxt   = ST_OPEN;
                    cmd_c    = 1'b1;
                    disarm_c = 1'b1;
                end else begin
                    st_nxt = restart_st;
                    cmd_c  = restart_cmd;
                end
            end
            ST_OPEN: begin
                qual_c = 1'b1;
            end
            default: begin
                st_nxt = ST_IDLE;
            end
        endcase
    end

    assign room       = (cnt_q < CNT_MAX);
    assign is_cmd     = ld_valid && cmd_c;
    assign allow      = ld_valid && !cmd_c && (qual_c ? room : !prot);
    assign open_o     = qual_c;
    assign arm_req    = ld_valid && !win_close && arm_c;
    assign disarm_req = ld_valid && !win_close && disarm_c;

    // State register: window close returns to idle, loads advance the detector.
    always_ff @(posedge clk) begin
        if (!rst_n || win_close) begin
            st_q <= ST_IDLE;
        end else if (ld_valid) begin
            st_q <= st_nxt;
        end
    end

    // Qualified data load counter, cleared per window.
    always_ff @(posedge clk) begin
        if (!rst_n || win_close) begin
            cnt_q <= '0;
        end else if (ld_valid && qual_c && room) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX); // R5
    AST_IDLE_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        win_close |=> (st_q == ST_IDLE && cnt_q == '0)); // R11
    AST_CMD_NEVER_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmd |-> !allow); // R4

endmodule

// File: rtl/swp_prot_reg.sv
// Protected flag with pending arm/disarm. Requests from the current window are
// held until win_close; disarm wins over arm. The flag resets to clear.
// Assumes at most one kind of request per window (guaranteed by the detector).
module swp_prot_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_req,
    input  logic disarm_req,
    input  logic win_close,
    output logic prot
);
    logic pend_arm_q, pend_dis_q, prot_q;

    // Collect requests during the window and clear them when it closes.
    always_ff @(posedge clk) begin
        if (!rst_n || win_close) begin
            pend_arm_q <= 1'b0;
            pend_dis_q <= 1'b0;
        end else begin
            if (arm_req)    pend_arm_q <= 1'b1;
            if (disarm_req) pend_dis_q <= 1'b1;
        end
    end

    // Commit the pending change at the end of the write period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q <= 1'b0;
        end else if (win_close) begin
            if (pend_dis_q)      prot_q <= 1'b0;
            else if (pend_arm_q) prot_q <= 1'b1;
        end
    end

    assign prot = prot_q;

    AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !win_close |=> $stable(prot_q)); // R10
    AST_PEND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pend_arm_q && pend_dis_q)); // R7

endmodule

// File: rtl/swp_seq.sv
// Top of the software write protection sequencer. It decodes each load against the
// five command steps, runs the step detector and holds the protected flag.
// ld_allow / ld_cmd are combinational for the presented load; prot_on is
// registered and moves one cycle after win_close.
module swp_seq
    import swp_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int ADDR_W     = 15,
    parameter int PAGE_WORDS = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_valid,
    input  logic [ADDR_W-1:0]  ld_addr,
    input  logic [8*LANES-1:0] ld_data,
    input  logic               win_close,
    output logic               ld_allow,
    output logic               ld_cmd,
    output logic               prot_on
);
    logic [NUM_TOK-1:0] tok;
    logic               open_w, arm_w, disarm_w, prot_w;

    // One step matcher per command token.
    for (genvar g = 0; g < NUM_TOK; g++) begin : g_tok
        swp_lane_match #(
            .LANES   (LANES),
            .ADDR_W  (ADDR_W),
            .KEY_ADDR(TOK_ADDR[g]),
            .KEY_BYTE(TOK_BYTE[g])
        ) match_i (
            .addr(ld_addr),
            .data(ld_data),
            .hit (tok[g])
        );
    end

    swp_step_fsm #(.PAGE_WORDS(PAGE_WORDS)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (ld_valid),
        .win_close (win_close),
        .tok       (tok),
        .prot      (prot_w),
        .is_cmd    (ld_cmd),
        .allow     (ld_allow),
        .open_o    (open_w),
        .arm_req   (arm_w),
        .disarm_req(disarm_w)
    );

    swp_prot_reg prot_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_req   (arm_w),
        .disarm_req(disarm_w),
        .win_close (win_close),
        .prot      (prot_w)
    );

    assign prot_on = prot_w;

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> (!ld_allow && !ld_cmd)); // R1
    AST_LOCKED_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_on && !open_w && ld_valid) |-> !ld_allow); // R3

endmodule

// File: tb/swp_seq_tb.sv
`timescale 1ns/1ps
module swp_seq_tb_top;
    localparam int LANES = 4;
    localparam int ADDR_W = 15;
    localparam int PAGE_WORDS = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_valid = 1'b0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic [8*LANES-1:0] ld_data = '0;
    logic win_close = 1'b0;
    logic ld_allow, ld_cmd, prot_on;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    swp_seq #(.LANES(LANES), .ADDR_W(ADDR_W), .PAGE_WORDS(PAGE_WORDS)) dut_i (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_data(ld_data), .win_close(win_close), .ld_allow(ld_allow),
        .ld_cmd(ld_cmd), .prot_on(prot_on)
    );

    function automatic logic [8*LANES-1:0] rep(input logic [7:0] b);
        return {LANES{b}};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one load; result sampled mid-cycle before the capturing edge.
    task automatic ld(input logic [ADDR_W-1:0] a, input logic [8*LANES-1:0] d,
                      output logic al, output logic cm);
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = a; ld_data = d;
        #1;
        al = ld_allow; cm = ld_cmd;
        @(posedge clk); #1;
        ld_valid = 1'b0;
    endtask

    task automatic ld_chk(input string req, input logic [ADDR_W-1:0] a,
                          input logic [8*LANES-1:0] d, input logic ea, input logic ec);
        logic al, cm;
        ld(a, d, al, cm);
        check({req, " allow"}, 32'(al), 32'(ea));
        check({req, " cmd"}, 32'(cm), 32'(ec));
    endtask

    task automatic close_win();
        @(negedge clk); win_close = 1'b1;
        @(posedge clk); #1; win_close = 1'b0;
    endtask

    task automatic prefix(input string req);
        ld_chk(req, 15'h5555, rep(8'hAA), 1'b0, 1'b1);
        ld_chk(req, 15'h2AAA, rep(8'h55), 1'b0, 1'b1);
        ld_chk(req, 15'h5555, rep(8'hA0), 1'b0, 1'b1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 prot after reset", 32'(prot_on), 0);
        check("R1 allow idle", 32'(ld_allow), 0);
        check("R1 cmd idle", 32'(ld_cmd), 0);
    endtask

    task automatic t_plain_open();
        ld_chk("R2 plain unprotected", 15'h0123, 32'h11223344, 1'b1, 1'b0);
        ld_chk("R2 plain second", 15'h0124, 32'hDEADBEEF, 1'b1, 1'b0);
        close_win();
        check("R2 prot stays clear", 32'(prot_on), 0);
    endtask

    task automatic t_enable();
        prefix("R4 prefix");
        @(negedge clk);
        check("R6 prot before close", 32'(prot_on), 0);
        close_win();
        check("R6 prot armed no data", 32'(prot_on), 1);
    endtask

    task automatic t_blocked();
        ld_chk("R3 plain protected", 15'h0040, 32'h01020304, 1'b0, 1'b0);
        close_win();
        check("R3 prot held", 32'(prot_on), 1);
    endtask

    task automatic t_unlock_page();
        logic al, cm;
        int ok = 0;
        prefix("R5 prefix");
        for (int i = 0; i < PAGE_WORDS; i++) begin
            ld(ADDR_W'(15'h0100 + i), 32'(i), al, cm);
            if (al && !cm) ok++;
        end
        check("R5 page loads allowed", 32'(ok), 32'(PAGE_WORDS));
        ld_chk("R5 load past page", 15'h0100, 32'h0, 1'b0, 1'b0);
        close_win();
        check("R6 prot still set", 32'(prot_on), 1);
    endtask

    task automatic t_new_window();
        ld_chk("R11 prefix part", 15'h5555, rep(8'hAA), 1'b0, 1'b1);
        ld_chk("R11 prefix part", 15'h2AAA, rep(8'h55), 1'b0, 1'b1);
        close_win();
        ld_chk("R11 fresh window no carry", 15'h5555, rep(8'hA0), 1'b0, 1'b0);
        close_win();
        prefix("R11 full prefix");
        ld_chk("R11 data in open window", 15'h0200, 32'h5A5A5A5A, 1'b1, 1'b0);
        close_win();
        ld_chk("R11 unlock does not carry", 15'h0201, 32'h5A5A5A5A, 1'b0, 1'b0);
        close_win();
    endtask

    task automatic t_mismatch();
        ld_chk("R8 step1", 15'h5555, rep(8'hAA), 1'b0, 1'b1);
        ld_chk("R8 repeat step1 restarts", 15'h5555, rep(8'hAA), 1'b0, 1'b1);
        ld_chk("R8 step2", 15'h2AAA, rep(8'h55), 1'b0, 1'b1);
        ld_chk("R8 step3", 15'h5555, rep(8'hA0), 1'b0, 1'b1);
        ld_chk("R8 data after restart", 15'h0300, 32'h12345678, 1'b1, 1'b0);
        close_win();
        ld_chk("R8 step1 again", 15'h5555, rep(8'hAA), 1'b0, 1'b1);
        ld_chk("R8 wrong step blocked", 15'h0100, 32'h12121212, 1'b0, 1'b0);
        ld_chk("R8 back to idle", 15'h2AAA, rep(8'h55), 1'b0, 1'b0);
        close_win();
    endtask

    task automatic t_lanes();
        ld_chk("R9 one lane off", 15'h5555, 32'hAAAA_AAAB, 1'b0, 1'b0);
        ld_chk("R9 top lane off", 15'h5555, 32'h2AAA_AAAA, 1'b0, 1'b0);
        ld_chk("R9 wrong address", 15'h5554, rep(8'hAA), 1'b0, 1'b0);
        close_win();
    endtask

    task automatic t_disable();
        ld_chk("R7 s1", 15'h5555, rep(8'hAA), 1'b0, 1'b1);
        ld_chk("R7 s2", 15'h2AAA, rep(8'h55), 1'b0, 1'b1);
        ld_chk("R7 s3", 15'h5555, rep(8'h80), 1'b0, 1'b1);
        ld_chk("R7 s4", 15'h5555, rep(8'hAA), 1'b0, 1'b1);
        ld_chk("R7 s5", 15'h2AAA, rep(8'h55), 1'b0, 1'b1);
        ld_chk("R7 s6", 15'h5555, rep(8'h20), 1'b0, 1'b1);
        check("R10 prot before close", 32'(prot_on), 1);
        ld_chk("R7 data after clear", 15'h0400, 32'hCAFEF00D, 1'b1, 1'b0);
        close_win();
        check("R7 prot cleared", 32'(prot_on), 0);
        ld_chk("R7 plain now open", 15'h0401, 32'h0, 1'b1, 1'b0);
        close_win();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_plain_open();
        t_enable();
        t_blocked();
        t_unlock_page();
        t_new_window();
        t_mismatch();
        t_lanes();
        t_disable();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule